// File: doc/BRIEF.md
# Programming mode entry controller

This block decides when the device enters its external programming mode and when it leaves it. It watches the raw reset pin and the reset-polarity select pin, and it takes a programming-enable fuse bit and a power-on-reset-active flag from neighbouring blocks. From these it drives a programming-mode-active signal that opens the programming port, and a session-locked flag. All pins are plain control levels, so there is no valid/ready stream and no back-pressure.

The reset pin passes through a synchronizer chain of `SYNC_STAGES` flops and is then mapped to an "asserted" level by the polarity pin. When the fuse is set, an asserted reset at any time opens a session. When the fuse is clear, a session can only start right after power-on reset ends, and only if reset was already asserted at that point. Once a fuse-clear session ends, every later entry is refused until the next power-on reset.

Top module: `prog_mode_ctrl`

## Requirements
- R1: The mode output `prog_active` rises only when the synchronized reset is asserted.
- R2: With `rst_pol` = 0 the reset pin is asserted when low. With `rst_pol` = 1 it is asserted when high.
- R3: With the fuse set (`isp_fuse` = 1) and no lock, `prog_active` rises on the (`SYNC_STAGES`+1)-th rising clock edge after the pin reaches its asserted level. It stays low after only `SYNC_STAGES` edges.
- R4: With the fuse clear, entry is allowed only on the first edge after `por_active` falls, and only if the synchronized reset was asserted on the last edge of power-on reset. Asserting reset later opens no session.
- R5: While active, `prog_active` stays high as long as the synchronized reset stays asserted. It falls on the (`SYNC_STAGES`+1)-th edge after the pin leaves its asserted level.
- R6: A session entered with the fuse clear sets `session_locked` when it ends. While locked, `prog_active` stays low whatever the pin and fuse do, and the two outputs are never high together.
- R7: An edge with `por_active` high clears both outputs. `session_locked` is cleared by nothing else.
- R8: The fuse value captured at entry decides whether the exit locks. Changing `isp_fuse` during a session neither ends the session nor changes that outcome.
- R9: A reset-pin pulse that starts and ends between two rising clock edges has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_active | input | 1 | High while power-on reset is in progress; acts as synchronous clear |
| rst_pin | input | 1 | Raw external reset pin, asynchronous |
| rst_pol | input | 1 | Reset polarity: 0 = asserted low, 1 = asserted high |
| isp_fuse | input | 1 | Programming-enable fuse: 1 = entry allowed at any time |
| prog_active | output | 1 | Programming mode active, gates the programming port |
| session_locked | output | 1 | A fuse-clear session has ended; entry is blocked until power-on reset |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default of 2. This checks that the generated chain length, and not a fixed count of two, sets the entry and exit latency. Every expected edge count in the directed checks and in the per-cycle reference model is derived from that one value. A deeper chain also means a short pin pulse must be missed by more flops, and it widens the gap between the pin change and the output change that the R3 and R5 checks sample.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic [1:0] {
    PM_IDLE   = 2'd0,
    PM_ACTIVE = 2'd1,
    PM_LOCKED = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] chain;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk) chain[g] <= chain[g-1];
    end
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/pme_level.sv
module pme_level (
  input  logic raw,
  input  logic pol_high,
  output logic asserted
);
  assign asserted = pol_high ? raw : ~raw;
endmodule

// File: rtl/pme_fsm.sv
module pme_fsm
  import pme_pkg::*;
(
  input  logic clk,
  input  logic por_active,
  input  logic rst_act,
  input  logic fuse_en,
  output logic active,
  output logic locked
);
  pm_state_e state;
  logic      por_grant;   // reset was asserted on the last POR edge
  logic      fuse_at_in;  // fuse value captured at entry

  always_ff @(posedge clk) begin
    if (por_active) begin
      state      <= PM_IDLE;
      por_grant  <= rst_act;
      fuse_at_in <= 1'b0;
    end else begin
      por_grant <= 1'b0;
      unique case (state)
        PM_IDLE: begin
          if (rst_act && (fuse_en || por_grant)) begin
            state      <= PM_ACTIVE;
            fuse_at_in <= fuse_en;
          end
        end
        PM_ACTIVE: begin
          if (!rst_act) state <= fuse_at_in ? PM_IDLE : PM_LOCKED;
        end
        PM_LOCKED: state <= PM_LOCKED;
        default:   state <= PM_IDLE;
      endcase
    end
  end

  assign active = (state == PM_ACTIVE);
  assign locked = (state == PM_LOCKED);
endmodule

// File: rtl/prog_mode_ctrl.sv
module prog_mode_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_active,
  input  logic rst_pin,
  input  logic rst_pol,
  input  logic isp_fuse,
  output logic prog_active,
  output logic session_locked
);
  logic pin_sync;
  logic rst_act;

  pme_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (rst_pin),
    .q   (pin_sync)
  );

  pme_level u_level (
    .raw      (pin_sync),
    .pol_high (rst_pol),
    .asserted (rst_act)
  );

  pme_fsm u_fsm (
    .clk        (clk),
    .por_active (por_active),
    .rst_act    (rst_act),
    .fuse_en    (isp_fuse),
    .active     (prog_active),
    .locked     (session_locked)
  );
endmodule

// File: rtl/prog_mode_chk.sv
module prog_mode_chk (
  input logic clk,
  input logic por_active,
  input logic rst_act,
  input logic isp_fuse,
  input logic prog_active,
  input logic session_locked
);
  AST_ENTRY_NEEDS_RESET: assert property (@(posedge clk) disable iff (por_active)
    $rose(prog_active) |-> $past(rst_act)); // R1

  AST_FUSE_CLEAR_WINDOW: assert property (@(posedge clk) disable iff (por_active)
    ($rose(prog_active) && !$past(isp_fuse)) |-> $past(por_active, 2)); // R4

  AST_HOLD_WHILE_RESET: assert property (@(posedge clk) disable iff (por_active)
    (prog_active && rst_act) |=> prog_active); // R5

  AST_EXIT_ON_RELEASE: assert property (@(posedge clk) disable iff (por_active)
    (prog_active && !rst_act) |=> !prog_active); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (por_active)
    session_locked |=> (session_locked && !prog_active)); // R6

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (por_active)
    !(prog_active && session_locked)); // R6

  AST_POR_CLEARS: assert property (@(posedge clk) disable iff (por_active)
    $fell(por_active) |-> (!prog_active && !session_locked)); // R7
endmodule

bind prog_mode_ctrl prog_mode_chk u_chk (
  .clk            (clk),
  .por_active     (por_active),
  .rst_act        (rst_act),
  .isp_fuse       (isp_fuse),
  .prog_active    (prog_active),
  .session_locked (session_locked)
);

// File: tb/sim_prog_mode_ctrl.sv
`timescale 1ns/1ps
module sim_prog_mode_ctrl;
  localparam int STG = 3;

  logic clk = 1'b0;
  logic por_active = 1'b1;
  logic rst_pin = 1'b1;
  logic rst_pol = 1'b0;
  logic isp_fuse = 1'b1;
  logic prog_active;
  logic session_locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prog_mode_ctrl #(.SYNC_STAGES(STG)) u0 (
    .clk            (clk),
    .por_active     (por_active),
    .rst_pin        (rst_pin),
    .rst_pol        (rst_pol),
    .isp_fuse       (isp_fuse),
    .prog_active    (prog_active),
    .session_locked (session_locked)
  );

  // Behavioural reference: pin history queue plus a mode integer
  // (0 idle, 1 in session, 2 locked out).
  bit pin_hist[$];
  int m_mode = 0;
  bit m_grant = 1'b0;
  bit m_fuse_seen = 1'b0;
  bit m_ok = 1'b0;

  always @(posedge clk) begin
    bit seen;
    bit act;
    seen = (pin_hist.size() >= STG) ? pin_hist[STG-1] : 1'b1;
    act  = rst_pol ? seen : !seen;
    if (por_active) begin
      m_mode = 0; m_grant = act; m_fuse_seen = 1'b0; m_ok = 1'b1;
    end else begin
      bit g;
      g = m_grant;
      m_grant = 1'b0;
      if (m_mode == 0 && act && (isp_fuse || g)) begin
        m_mode = 1; m_fuse_seen = isp_fuse;
      end else if (m_mode == 1 && !act) begin
        m_mode = m_fuse_seen ? 0 : 2;
      end
    end
    pin_hist.push_front(rst_pin);
    if (pin_hist.size() > 8) void'(pin_hist.pop_back());
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_ok && !done) begin
      chk("R3 model prog_active", prog_active, m_mode == 1);
      chk("R6 model session_locked", session_locked, m_mode == 2);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Power-on reset with the given pin level, polarity and fuse.
  task automatic power_on(input logic pin, input logic pol, input logic fuse);
    @(negedge clk);
    por_active = 1'b1; rst_pin = pin; rst_pol = pol; isp_fuse = fuse;
    tick(1);
    chk("R7 outputs low in POR (prog)", prog_active, 1'b0);
    chk("R7 outputs low in POR (lock)", session_locked, 1'b0);
    tick(STG + 2);
    por_active = 1'b0;
  endtask

  task automatic finish_sim;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_sim();
  end

  initial begin
    // Reset pin inactive (active-low polarity, pin high), fuse set.
    power_on(1'b1, 1'b0, 1'b1);
    tick(STG + 3);
    chk("R1 no entry without reset", prog_active, 1'b0);

    // R3 entry latency with the fuse set.
    rst_pin = 1'b0;
    tick(STG);
    chk("R3 not yet after STG edges", prog_active, 1'b0);
    tick(1);
    chk("R3 entry after STG+1 edges", prog_active, 1'b1);
    tick(6);
    chk("R5 holds while reset asserted", prog_active, 1'b1);
    rst_pin = 1'b1;
    tick(STG);
    chk("R5 still active before exit", prog_active, 1'b1);
    tick(1);
    chk("R5 exit after release", prog_active, 1'b0);
    chk("R6 fuse set: no lock", session_locked, 1'b0);

    // R9: pulse entirely between two rising edges.
    #0.5 rst_pin = 1'b0;
    #1.0 rst_pin = 1'b1;
    tick(STG + 3);
    chk("R9 short pulse ignored", prog_active, 1'b0);
    chk("R9 short pulse no lock", session_locked, 1'b0);

    // R2: active-high polarity, fuse set.
    power_on(1'b0, 1'b1, 1'b1);
    tick(STG + 2);
    chk("R2 low pin inactive when pol=1", prog_active, 1'b0);
    rst_pin = 1'b1;
    tick(STG + 1);
    chk("R2 high pin enters when pol=1", prog_active, 1'b1);
    rst_pin = 1'b0;
    tick(STG + 1);
    chk("R2 low pin exits when pol=1", prog_active, 1'b0);

    // R4: fuse clear, reset not asserted during POR, asserted later.
    power_on(1'b1, 1'b0, 1'b0);
    tick(2);
    rst_pin = 1'b0;
    tick(STG + 5);
    chk("R4 late reset refused (fuse clear)", prog_active, 1'b0);
    chk("R4 late reset no lock", session_locked, 1'b0);
    rst_pin = 1'b1;

    // R4/R8/R6: fuse clear, reset held through POR.
    power_on(1'b0, 1'b0, 1'b0);
    tick(1);
    chk("R4 entry on first edge after POR", prog_active, 1'b1);
    isp_fuse = 1'b1;
    tick(4);
    chk("R8 fuse change keeps session", prog_active, 1'b1);
    rst_pin = 1'b1;
    tick(STG + 1);
    chk("R5 exit fuse-clear session", prog_active, 1'b0);
    chk("R8 lock follows fuse at entry", session_locked, 1'b1);
    rst_pin = 1'b0;
    tick(STG + 5);
    chk("R6 locked refuses entry (fuse set)", prog_active, 1'b0);
    chk("R6 lock persists", session_locked, 1'b1);
    isp_fuse = 1'b0;
    rst_pin = 1'b1;
    tick(4);
    chk("R7 lock kept without POR", session_locked, 1'b1);

    // R7 lock cleared by POR; R8 fuse cleared mid-session does not lock.
    power_on(1'b1, 1'b0, 1'b1);
    tick(1);
    chk("R7 lock cleared by POR", session_locked, 1'b0);
    rst_pin = 1'b0;
    tick(STG + 1);
    chk("R8 entry with fuse set", prog_active, 1'b1);
    isp_fuse = 1'b0;
    tick(3);
    chk("R8 fuse clear keeps session", prog_active, 1'b1);
    rst_pin = 1'b1;
    tick(STG + 1);
    chk("R8 exit no lock (fuse was set)", session_locked, 1'b0);
    rst_pin = 1'b0;
    tick(STG + 4);
    chk("R4 re-entry refused with fuse clear", prog_active, 1'b0);
    rst_pin = 1'b1;

    // R2 + R4: active-high polarity, fuse clear, reset high through POR.
    power_on(1'b1, 1'b1, 1'b0);
    tick(1);
    chk("R2 pol=1 entry at POR end", prog_active, 1'b1);
    rst_pin = 1'b0;
    tick(STG + 1);
    chk("R6 pol=1 exit locks", session_locked, 1'b1);
    tick(2);

    finish_sim();
  end
endmodule